// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block sits behind the bit shifter of a serial-flash slave. It receives whole bytes, already deserialised, framed by an active-low chip-select. The first byte of each frame is an opcode. What follows depends on the opcode: address bytes for array commands, one data byte for the bank register, or dummy bytes clocked by the host while the block supplies response bytes.

Array commands are read, fast read, the page-program family and the three erase sizes. For these the block collects an address and hands the finished byte address and the opcode to a separate storage port as a one-cycle request. The address takes one of two forms:
- In 3-byte mode it is a 24-bit offset placed within one of four 16 MiB banks, selected by a bank register.
- In 4-byte mode it is a native 32-bit address.

The block holds the addressing mode, the bank register, a write-enable latch and a reset-armed flag. It answers identity, flag-status and bank-register reads itself.

Top module: `spi_nor_cmd_fe`

## Requirements
- R1: After `rst_n` is low, `tx_byte` is 0xFF, `mem_req` is 0, the block is in 3-byte mode, and the bank register, write-enable and reset-armed flag are all 0.
- R2: Opcode 0xB7 selects 4-byte mode and opcode 0xE9 selects 3-byte mode; neither consumes further bytes.
- R3: In 3-byte mode an array opcode (0x03, 0x0B, 0x02, 0xA2, 0x32, 0x20, 0x52, 0xD8) is followed by three address bytes, most-significant first. One cycle after the third byte, `mem_req` is high for exactly one cycle. `mem_cmd` holds the opcode and `mem_addr` = 24-bit value + bank[1:0] × 0x1000000.
- R4: In 4-byte mode an array opcode takes four address bytes, most-significant first. `mem_addr` is that 32-bit value, and the bank register has no effect.
- R5: Opcode 0xC5 loads the bank register from the next byte only while write-enable is set; otherwise the register is unchanged. Opcode 0xC8 makes the register value the next `tx_byte`.
- R6: Opcode 0x66 arms the software reset. Opcode 0x99 without the arm changes nothing, and the arm survives other commands.
- R7: An armed 0x99 clears the bank register, 4-byte mode, write-enable, the arm, the stored command and address, and all counters.
- R8: After opcode 0x70, `tx_byte` is 0x80 (bit 7 = ready) for every byte until chip-select rises.
- R9: After opcode 0x9F, `tx_byte` gives the 24-bit identity (default 0x20BA19) high byte first, then 0xFF.
- R10: A rise of `cs_n` abandons a partial address without a request and forces `tx_byte` to 0xFF; the next frame's first byte is an opcode. Mode and bank state persist across frames.
- R11: An unknown opcode changes no state, and `tx_byte` is 0xFF for the rest of the frame.
- R12: Opcode 0x06 sets write-enable, which persists until a software reset or `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low; high ends a frame |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| mem_req | output | 1 | One-cycle pulse: address and command ready for the array |
| mem_cmd | output | 8 | Opcode of the array command |
| mem_addr | output | 32 | Assembled byte address |

## Verification
Every result appears one clock after the edge that takes its cause. `tx_byte` changes one cycle after the `rx_valid` of the byte that selects it. `mem_req` rises one cycle after the last address byte and falls on the next cycle. The effect of a `cs_n` rise shows one cycle later. The bench drives each byte at a falling edge and holds it for one rising edge. It samples on the following falling edge, which is exactly the cycle those results are due, and it checks `mem_req` low again one cycle later.

// File: rtl/spi_nor_cmd_fe.sv
`timescale 1ns/1ps
module spi_nor_cmd_fe #(
  parameter logic [23:0] ID_CODE    = 24'h20BA19,
  parameter logic [7:0]  FLAG_READY = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [7:0]  tx_byte,
  output logic        mem_req,
  output logic [7:0]  mem_cmd,
  output logic [31:0] mem_addr
);
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_4B_ON = 8'hB7;
  localparam logic [7:0] OP_4B_OFF= 8'hE9;
  localparam logic [7:0] OP_BANKW = 8'hC5;
  localparam logic [7:0] OP_BANKR = 8'hC8;
  localparam logic [7:0] OP_ARM   = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;
  localparam logic [7:0] OP_FLAG  = 8'h70;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] IDLE_TX  = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_BANKW, ST_IDENT, ST_FLAG, ST_SINK} st_t;

  st_t         st;
  logic [23:0] sh;
  logic [1:0]  cnt;
  logic        four_b, wel, armed;
  logic [7:0]  bank;

  logic is_array_op, last_addr;
  assign is_array_op = rx_byte inside {8'h03, 8'h0B, 8'h02, 8'hA2, 8'h32, 8'h20, 8'h52, 8'hD8};
  assign last_addr   = (cnt == (four_b ? 2'd3 : 2'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; cnt <= '0;
      four_b <= 1'b0; wel <= 1'b0; armed <= 1'b0; bank <= '0;
      tx_byte <= IDLE_TX; mem_req <= 1'b0; mem_cmd <= '0; mem_addr <= '0;
    end else begin
      mem_req <= 1'b0;
      if (cs_n) begin
        st <= ST_IDLE; cnt <= '0; tx_byte <= IDLE_TX;
      end else if (rx_valid) begin
        case (st)
          ST_IDLE: begin
            tx_byte <= IDLE_TX;
            st      <= ST_SINK;
            if (is_array_op) begin
              st <= ST_ADDR; cnt <= '0; mem_cmd <= rx_byte;
            end else begin
              case (rx_byte)
                OP_WEN:    wel <= 1'b1;
                OP_4B_ON:  four_b <= 1'b1;
                OP_4B_OFF: four_b <= 1'b0;
                OP_ARM:    armed <= 1'b1;
                OP_RST: if (armed) begin
                  st <= ST_IDLE; sh <= '0; cnt <= '0;
                  four_b <= 1'b0; wel <= 1'b0; armed <= 1'b0; bank <= '0;
                  mem_cmd <= '0; mem_addr <= '0;
                end
                OP_BANKW: if (wel) st <= ST_BANKW;
                OP_BANKR: tx_byte <= bank;
                OP_FLAG: begin tx_byte <= FLAG_READY; st <= ST_FLAG; end
                OP_IDENT: begin tx_byte <= ID_CODE[23:16]; st <= ST_IDENT; cnt <= '0; end
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            sh  <= {sh[15:0], rx_byte};
            cnt <= cnt + 2'd1;
            if (last_addr) begin
              mem_req  <= 1'b1;
              mem_addr <= four_b ? {sh, rx_byte} : {6'd0, bank[1:0], sh[15:0], rx_byte};
              st       <= ST_SINK;
            end
          end
          ST_BANKW: begin bank <= rx_byte; st <= ST_SINK; end
          ST_IDENT: begin
            cnt <= cnt + 2'd1;
            case (cnt)
              2'd0:    tx_byte <= ID_CODE[15:8];
              2'd1:    tx_byte <= ID_CODE[7:0];
              default: begin tx_byte <= IDLE_TX; st <= ST_SINK; end
            endcase
          end
          ST_FLAG: tx_byte <= FLAG_READY;
          default: tx_byte <= IDLE_TX;
        endcase
      end
    end
  end
endmodule

module spi_nor_cmd_fe_chk #(
  parameter logic [7:0] FLAG_READY = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rx_valid,
  input logic [7:0]  rx_byte,
  input logic [7:0]  tx_byte,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        at_idle,
  input logic        at_flag,
  input logic        four_b,
  input logic        wel,
  input logic        armed,
  input logic [7:0]  bank
);
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_bank_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !four_b) |-> (mem_addr[31:26] == 6'd0));

  p_bank_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_idle && rx_valid && !cs_n && rx_byte == 8'hC5 && !wel) |=> $stable(bank));

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_idle && rx_valid && !cs_n && rx_byte == 8'h99 && armed)
      |=> (!wel && !four_b && !armed && bank == 8'd0));

  p_flag_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_flag && rx_valid && !cs_n) |=> (tx_byte == FLAG_READY));

  p_frame_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'hFF && !mem_req));
endmodule

bind spi_nor_cmd_fe spi_nor_cmd_fe_chk #(.FLAG_READY(FLAG_READY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .tx_byte(tx_byte), .mem_req(mem_req), .mem_addr(mem_addr),
  .at_idle(st == ST_IDLE), .at_flag(st == ST_FLAG),
  .four_b(four_b), .wel(wel), .armed(armed), .bank(bank));

// File: tb/spi_nor_cmd_fe_test.sv
`timescale 1ns/1ps
module spi_nor_cmd_fe_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_byte, mem_cmd;
  logic mem_req;
  logic [31:0] mem_addr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_nor_cmd_fe uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .mem_req(mem_req), .mem_cmd(mem_cmd),
    .mem_addr(mem_addr));

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  nb;
    logic [39:0] bytes;
    logic [39:0] tx;
    logic        req;
    logic [7:0]  cmd;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{4'd9,  3'd4, 40'h9F00000000, 40'h20BA19FF00, 1'b0, 8'h00, 32'h0},        // R9 identity
    '{4'd8,  3'd4, 40'h7000000000, 40'h8080808000, 1'b0, 8'h00, 32'h0},        // R8 flag repeats
    '{4'd3,  3'd4, 40'h0312345600, 40'hFFFFFFFF00, 1'b1, 8'h03, 32'h00123456}, // R3 bank 0
    '{4'd5,  3'd2, 40'hC502000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0},        // R5 locked write
    '{4'd5,  3'd2, 40'hC800000000, 40'h00FF000000, 1'b0, 8'h00, 32'h0},        // R5 unchanged
    '{4'd12, 3'd1, 40'h0600000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R12
    '{4'd5,  3'd2, 40'hC502000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0},        // R5 write bank 2
    '{4'd5,  3'd2, 40'hC800000000, 40'h02FF000000, 1'b0, 8'h00, 32'h0},        // R5 readback
    '{4'd3,  3'd4, 40'h02ABCDEF00, 40'hFFFFFFFF00, 1'b1, 8'h02, 32'h02ABCDEF}, // R3 bank 2
    '{4'd2,  3'd1, 40'hB700000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R2 enter 4B
    '{4'd4,  3'd5, 40'hD801020304, 40'hFFFFFFFFFF, 1'b1, 8'hD8, 32'h01020304}, // R4 bank ignored
    '{4'd2,  3'd1, 40'hE900000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R2 leave 4B
    '{4'd2,  3'd4, 40'h2000100000, 40'hFFFFFFFF00, 1'b1, 8'h20, 32'h02001000}, // R2 back to 3B
    '{4'd11, 3'd2, 40'h5500000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0},        // R11 unknown
    '{4'd6,  3'd1, 40'h6600000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R6 arm
    '{4'd6,  3'd2, 40'hC800000000, 40'h02FF000000, 1'b0, 8'h00, 32'h0},        // R6 arm keeps bank
    '{4'd7,  3'd1, 40'h9900000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R7 reset
    '{4'd7,  3'd2, 40'hC800000000, 40'h00FF000000, 1'b0, 8'h00, 32'h0},        // R7 bank cleared
    '{4'd12, 3'd1, 40'h0600000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R12
    '{4'd5,  3'd2, 40'hC503000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0},        // R5 bank 3
    '{4'd6,  3'd1, 40'h9900000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R6 unarmed reset
    '{4'd6,  3'd2, 40'hC800000000, 40'h03FF000000, 1'b0, 8'h00, 32'h0},        // R6 no effect
    '{4'd2,  3'd1, 40'hB700000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R2
    '{4'd6,  3'd1, 40'h6600000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R6
    '{4'd7,  3'd1, 40'h9900000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0},        // R7
    '{4'd7,  3'd4, 40'h0300000100, 40'hFFFFFFFF00, 1'b1, 8'h03, 32'h00000001}, // R7 3B, bank 0
    '{4'd7,  3'd2, 40'hC501000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0},        // R7 wel cleared
    '{4'd7,  3'd2, 40'hC800000000, 40'h00FF000000, 1'b0, 8'h00, 32'h0}         // R7
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input int n, input logic [39:0] b, input logic [39:0] tx,
                       input logic req, input logic [7:0] cmd, input logic [31:0] addr,
                       input string tag);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = b[39-8*i -: 8]; end
      @(negedge clk) rx_valid = 1'b0;
      chk(tx_byte == tx[39-8*i -: 8], {tag, " tx"}, 32'(tx_byte), 32'(tx[39-8*i -: 8]));
      if (req && i == n-1) begin
        chk(mem_req == 1'b1, {tag, " req"}, 32'(mem_req), 32'd1);
        chk(mem_addr == addr, {tag, " addr"}, mem_addr, addr);
        chk(mem_cmd == cmd, {tag, " cmd"}, 32'(mem_cmd), 32'(cmd));
      end else begin
        chk(mem_req == 1'b0, {tag, " no req"}, 32'(mem_req), 32'd0);
      end
    end
    if (req) begin
      @(negedge clk);
      chk(mem_req == 1'b0, {tag, " req one cycle"}, 32'(mem_req), 32'd0);
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_byte == 8'hFF, "R1 reset tx", 32'(tx_byte), 32'hFF);
    chk(mem_req == 1'b0, "R1 reset req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    frame(2, 40'hC800000000, 40'h00FF000000, 1'b0, 8'h00, 32'h0, "R1 bank zero");

    for (int k = 0; k < NV; k++)
      frame(int'(TBL[k].nb), TBL[k].bytes, TBL[k].tx, TBL[k].req, TBL[k].cmd, TBL[k].addr,
            $sformatf("R%0d vector %0d", TBL[k].rq, k));

    // R10 partial address abandoned
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'h03; end
    @(negedge clk) rx_byte = 8'h11;
    @(negedge clk) begin rx_valid = 1'b0; cs_n = 1'b1; end
    @(negedge clk);
    chk(tx_byte == 8'hFF, "R10 abort tx", 32'(tx_byte), 32'hFF);
    chk(mem_req == 1'b0, "R10 abort req", 32'(mem_req), 32'd0);
    frame(1, 40'h9F00000000, 40'h2000000000, 1'b0, 8'h00, 32'h0, "R10 new opcode");

    // R10 flag stream ends on cs rise
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'h70; end
    @(negedge clk) begin rx_valid = 1'b0; cs_n = 1'b1; end
    @(negedge clk);
    chk(tx_byte == 8'hFF, "R10 flag end", 32'(tx_byte), 32'hFF);

    // R10 mode persists across frames
    frame(1, 40'hB700000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0, "R10 enter 4B");
    frame(5, 40'h0BAABBCCDD, 40'hFFFFFFFFFF, 1'b1, 8'h0B, 32'hAABBCCDD, "R10 4B persists");

    // R1 hardware reset mid-operation returns to 3-byte mode
    frame(1, 40'h0600000000, 40'hFF00000000, 1'b0, 8'h00, 32'h0, "R1 wel");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(tx_byte == 8'hFF, "R1 rst tx", 32'(tx_byte), 32'hFF);
    rst_n = 1'b1;
    frame(4, 40'h3201020300, 40'hFFFFFFFF00, 1'b1, 8'h32, 32'h00010203, "R1 3B after reset");
    frame(2, 40'hC501000000, 40'hFFFF000000, 1'b0, 8'h00, 32'h0, "R1 wel cleared");
    frame(2, 40'hC800000000, 40'h00FF000000, 1'b0, 8'h00, 32'h0, "R1 bank kept 0");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule